// File: doc/BRIEF.md
# Circular Command Queue Processor

This block drains fixed-size command packets from a ring buffer that lives in system memory. Software writes packets into the ring and then publishes a new write offset; the block fetches each packet's first 64-bit doubleword from memory, classifies its opcode, and either finishes the packet itself or hands it to a downstream command handler. After each packet it moves its read offset forward one slot, wrapping at the end of the ring. Software watches the read offset to learn how far the queue has been consumed.

The ring is 32 bytes per packet and is sized in 4 KB units. A small size field selects how many units the ring spans. Two opcodes are handled locally. A synchronisation packet is simply consumed. An invalidate-all packet sends a one-cycle refresh pulse to every target processor. All other opcodes are forwarded with the whole first doubleword, and the handler answers with either continue or stall. A bus error on a fetch, or a stall answer, freezes the queue with its read offset left on the offending packet and raises a sticky stalled flag. An offset that lies outside the ring raises a one-cycle configuration-error pulse and nothing is fetched.

Top module: `cmdq_proc`

## Requirements
- R1: After reset the read offset is 0, the stalled flag is 0, and neither a memory request nor a dispatch is active.
- R2: While the enable input is 0 no packet is fetched; a pending write-offset update is kept and is worked off once enable returns to 1.
- R3: When a pending update finds the write offset or the read offset at or above the ring's entry count, the block pulses cfg_err_o for one cycle, fetches nothing and leaves the read offset unchanged.
- R4: The entry count is (size_i + 1) × 4096 / 32, which is 128 entries per unit of size_i.
- R5: Packets are fetched one at a time while the read offset differs from the write offset, at byte address base_i + read offset × 32.
- R6: A fetch that returns with mem_rerr_i set raises the stalled flag, leaves the read offset unchanged and dispatches nothing.
- R7: Each completed packet advances the read offset by one; the offset that would equal the entry count wraps to 0.
- R8: A handler reply with disp_stall_i set raises the stalled flag and leaves the read offset on the stalled packet.
- R9: Opcode 8'h05 (low 8 bits of the first doubleword) is consumed without dispatch and the offset advances.
- R10: Opcode 8'h0D drives refresh_o to all ones for exactly one cycle, is not dispatched, and the offset advances.
- R11: Every other opcode is dispatched: disp_opcode_o carries bits 7:0 and disp_dw0_o the whole first doubleword, held until disp_done_i.
- R12: Write-offset updates arriving while packets are being processed are captured; processing continues up to the newest write offset.
- R13: The stalled flag holds until reset, and no fetch is issued while it is set, even after further write-offset updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Queue processing enable |
| base_i | input | AW | Byte address of ring slot 0 |
| size_i | input | SZ_W | Ring size in 4 KB units, minus one |
| wr_off_i | input | OFF_W | Producer write offset, in packets |
| wr_upd_i | input | 1 | One-cycle pulse: wr_off_i holds a new value |
| mem_req_o | output | 1 | Doubleword read request, held until answered |
| mem_addr_o | output | AW | Byte address of the requested doubleword |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rerr_i | input | 1 | Read response carries a bus error |
| mem_rdata_i | input | 64 | Read response data |
| disp_valid_o | output | 1 | Packet offered to the handler, held until done |
| disp_opcode_o | output | 8 | Opcode of the offered packet |
| disp_dw0_o | output | 64 | First doubleword of the offered packet |
| disp_done_i | input | 1 | Handler finished the packet |
| disp_stall_i | input | 1 | With disp_done_i: handler asks the queue to stall |
| rd_off_o | output | OFF_W | Consumer read offset, in packets |
| stalled_o | output | 1 | Sticky stalled flag |
| cfg_err_o | output | 1 | One-cycle pulse on an out-of-range offset |
| refresh_o | output | NCPU | One-cycle refresh pulse to each target processor |

## Verification
The assertions assume one outstanding read at a time: mem_rvalid_i only comes while mem_req_o is high, and disp_done_i only while disp_valid_o is high, each for a single cycle per request. The bench's memory and handler models respond exactly once per request, on the falling edge after seeing it, and drop the response on the next falling edge, so those assumptions always hold. The ring size is not changed while packets are in flight, which keeps the read offset inside the ring that the step check relies on.

// File: rtl/cqp_pkg.sv
package cqp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DISP  = 2'd2
    } cqp_state_e;

    typedef enum logic [1:0] {
        OPK_SYNC    = 2'd0,
        OPK_REFRESH = 2'd1,
        OPK_FORWARD = 2'd2
    } cqp_opkind_e;

    localparam logic [7:0] OPC_SYNC    = 8'h05;
    localparam logic [7:0] OPC_REFRESH = 8'h0D;

endpackage

// File: rtl/cqp_geom.sv
module cqp_geom #(
    parameter int AW         = 48,
    parameter int SZ_W       = 8,
    parameter int OFF_W      = 15,
    parameter int PKT_SHIFT  = 5,
    parameter int UNIT_SHIFT = 7
) (
    input  logic [SZ_W-1:0]  size_i,
    input  logic [AW-1:0]    base_i,
    input  logic [OFF_W-1:0] rd_i,
    input  logic [OFF_W-1:0] wr_i,
    output logic [OFF_W:0]   count_o,
    output logic [OFF_W-1:0] rd_next_o,
    output logic [AW-1:0]    pkt_addr_o,
    output logic             bad_range_o
);
    localparam int CW = OFF_W + 1;

    logic [CW-1:0] units;
    logic [CW-1:0] rd_inc;

    always_comb begin
        units       = CW'(size_i) + CW'(1);
        count_o     = units << UNIT_SHIFT;
        rd_inc      = {1'b0, rd_i} + CW'(1);
        rd_next_o   = (rd_inc >= count_o) ? '0 : rd_inc[OFF_W-1:0];
        pkt_addr_o  = base_i + (AW'(rd_i) << PKT_SHIFT);
        bad_range_o = ({1'b0, wr_i} >= count_o) || ({1'b0, rd_i} >= count_o);
    end

endmodule

// File: rtl/cqp_decode.sv
module cqp_decode
    import cqp_pkg::*;
(
    input  logic [7:0]  opcode_i,
    output cqp_opkind_e kind_o
);
    always_comb begin
        case (opcode_i)
            OPC_SYNC:    kind_o = OPK_SYNC;
            OPC_REFRESH: kind_o = OPK_REFRESH;
            default:     kind_o = OPK_FORWARD;
        endcase
    end

endmodule

// File: rtl/cmdq_proc.sv
module cmdq_proc
    import cqp_pkg::*;
#(
    parameter int AW         = 48,
    parameter int SZ_W       = 8,
    parameter int PAGE_BYTES = 4096,
    parameter int PKT_BYTES  = 32,
    parameter int NCPU       = 4,
    parameter int OFF_W      = $clog2((2 ** SZ_W) * (PAGE_BYTES / PKT_BYTES))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [AW-1:0]    base_i,
    input  logic [SZ_W-1:0]  size_i,
    input  logic [OFF_W-1:0] wr_off_i,
    input  logic             wr_upd_i,
    output logic             mem_req_o,
    output logic [AW-1:0]    mem_addr_o,
    input  logic             mem_rvalid_i,
    input  logic             mem_rerr_i,
    input  logic [63:0]      mem_rdata_i,
    output logic             disp_valid_o,
    output logic [7:0]       disp_opcode_o,
    output logic [63:0]      disp_dw0_o,
    input  logic             disp_done_i,
    input  logic             disp_stall_i,
    output logic [OFF_W-1:0] rd_off_o,
    output logic             stalled_o,
    output logic             cfg_err_o,
    output logic [NCPU-1:0]  refresh_o
);
    localparam int PKT_SHIFT  = $clog2(PKT_BYTES);
    localparam int UNIT_SHIFT = $clog2(PAGE_BYTES / PKT_BYTES);

    typedef struct packed {
        cqp_state_e       state;
        logic [OFF_W-1:0] rd;
        logic [OFF_W-1:0] wr;
        logic             pend;
        logic             stalled;
        logic             cfg_err;
        logic             refresh;
        logic [63:0]      dw0;
    } cqp_regs_t;

    cqp_regs_t r_d, r_q;

    logic [OFF_W:0]   count;
    logic [OFF_W-1:0] rd_next;
    logic [AW-1:0]    pkt_addr;
    logic             bad_range;
    cqp_opkind_e      kind;

    cqp_geom #(
        .AW(AW), .SZ_W(SZ_W), .OFF_W(OFF_W),
        .PKT_SHIFT(PKT_SHIFT), .UNIT_SHIFT(UNIT_SHIFT)
    ) u_geom (
        .size_i     (size_i),
        .base_i     (base_i),
        .rd_i       (r_q.rd),
        .wr_i       (r_q.wr),
        .count_o    (count),
        .rd_next_o  (rd_next),
        .pkt_addr_o (pkt_addr),
        .bad_range_o(bad_range)
    );

    cqp_decode u_dec (
        .opcode_i(mem_rdata_i[7:0]),
        .kind_o  (kind)
    );

    always_comb begin
        r_d         = r_q;
        r_d.cfg_err = 1'b0;
        r_d.refresh = 1'b0;
        if (wr_upd_i) begin
            r_d.wr   = wr_off_i;
            r_d.pend = 1'b1;
        end
        case (r_q.state)
            ST_IDLE: begin
                if (r_q.pend && enable_i && !r_q.stalled) begin
                    if (bad_range) begin
                        r_d.cfg_err = 1'b1;
                        r_d.pend    = wr_upd_i;
                    end else if (r_q.rd == r_q.wr) begin
                        r_d.pend = wr_upd_i;
                    end else begin
                        r_d.state = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_rvalid_i) begin
                    if (mem_rerr_i) begin
                        r_d.stalled = 1'b1;
                        r_d.state   = ST_IDLE;
                    end else begin
                        r_d.dw0 = mem_rdata_i;
                        case (kind)
                            OPK_SYNC: begin
                                r_d.rd    = rd_next;
                                r_d.state = ST_IDLE;
                            end
                            OPK_REFRESH: begin
                                r_d.refresh = 1'b1;
                                r_d.rd      = rd_next;
                                r_d.state   = ST_IDLE;
                            end
                            default: r_d.state = ST_DISP;
                        endcase
                    end
                end
            end
            ST_DISP: begin
                if (disp_done_i) begin
                    if (disp_stall_i) r_d.stalled = 1'b1;
                    else              r_d.rd      = rd_next;
                    r_d.state = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_req_o     = (r_q.state == ST_FETCH);
    assign mem_addr_o    = pkt_addr;
    assign disp_valid_o  = (r_q.state == ST_DISP);
    assign disp_opcode_o = r_q.dw0[7:0];
    assign disp_dw0_o    = r_q.dw0;
    assign rd_off_o      = r_q.rd;
    assign stalled_o     = r_q.stalled;
    assign cfg_err_o     = r_q.cfg_err;

    for (genvar g = 0; g < NCPU; g++) begin : g_refresh
        assign refresh_o[g] = r_q.refresh;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (rd_off_o == '0 && !stalled_o && !mem_req_o && !disp_valid_o)); // R1
    AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n) (!enable_i && !mem_req_o && !disp_valid_o) |=> !mem_req_o); // R2
    AST_ERR_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n) cfg_err_o |-> !mem_req_o); // R3
    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n) !$stable(rd_off_o) |-> (rd_off_o == $past(rd_off_o) + 1'b1 || rd_off_o == '0)); // R7
    AST_STALL_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(stalled_o) |-> $stable(rd_off_o)); // R8
    AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n) !(mem_req_o && disp_valid_o)); // R11
    AST_REFRESH_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (refresh_o != '0) |=> (refresh_o == '0)); // R10
    AST_STALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n) stalled_o |=> stalled_o); // R13
    AST_STALL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) stalled_o |-> !mem_req_o); // R13

endmodule

// File: tb/sim_cmdq_proc.sv
`timescale 1ns/1ps
module sim_cmdq_proc;
    localparam int AW = 48;
    localparam int OW = 15;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1;
    logic [AW-1:0] base = 48'h0000_1234_5000;
    logic [7:0] size = 8'd0;
    logic [OW-1:0] wr = '0;
    logic wr_upd = 1'b0;
    logic mem_req;
    logic [AW-1:0] mem_addr;
    logic mem_rvalid = 1'b0;
    logic mem_rerr = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic disp_valid;
    logic [7:0] disp_op;
    logic [63:0] disp_dw0;
    logic disp_done = 1'b0;
    logic disp_stall = 1'b0;
    logic [OW-1:0] rd;
    logic stalled;
    logic cfg_err;
    logic [NC-1:0] refresh;

    cmdq_proc u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(en), .base_i(base), .size_i(size),
        .wr_off_i(wr), .wr_upd_i(wr_upd),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
        .mem_rerr_i(mem_rerr), .mem_rdata_i(mem_rdata),
        .disp_valid_o(disp_valid), .disp_opcode_o(disp_op), .disp_dw0_o(disp_dw0),
        .disp_done_i(disp_done), .disp_stall_i(disp_stall),
        .rd_off_o(rd), .stalled_o(stalled), .cfg_err_o(cfg_err), .refresh_o(refresh)
    );

    always #2 clk = ~clk;

    int tests = 0;
    int fails = 0;
    logic [7:0] cur_op = 8'h05;
    logic berr_mode = 1'b0;
    logic hstall_mode = 1'b0;
    int n_fetch = 0, n_disp = 0, n_ref = 0, n_ref_bad = 0, n_err = 0;
    logic [AW-1:0] last_addr = '0;
    logic [63:0] last_dw0 = '0;
    logic [7:0] last_op = '0;

    typedef struct packed {
        logic [7:0] op;
        logic       berr;
        logic       hstall;
        logic [3:0] exp_rd;
        logic       exp_st;
        logic [3:0] exp_disp;
        logic [3:0] exp_ref;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{8'h05, 1'b0, 1'b0, 4'd2, 1'b0, 4'd0, 4'd0},
        '{8'h0D, 1'b0, 1'b0, 4'd2, 1'b0, 4'd0, 4'd2},
        '{8'h03, 1'b0, 1'b0, 4'd2, 1'b0, 4'd2, 4'd0},
        '{8'h0A, 1'b0, 1'b1, 4'd0, 1'b1, 4'd1, 4'd0},
        '{8'h05, 1'b1, 1'b0, 4'd0, 1'b1, 4'd0, 4'd0},
        '{8'h0A, 1'b1, 1'b0, 4'd0, 1'b1, 4'd0, 4'd0}
    };

    // memory model: one response per request
    initial forever begin
        @(negedge clk);
        if (mem_rvalid) begin
            mem_rvalid = 1'b0;
            mem_rerr   = 1'b0;
        end else if (mem_req) begin
            mem_rvalid = 1'b1;
            mem_rerr   = berr_mode;
            mem_rdata  = {8'h00, mem_addr, cur_op};
            last_addr  = mem_addr;
            n_fetch++;
        end
    end

    // handler model
    initial forever begin
        @(negedge clk);
        if (disp_done) begin
            disp_done  = 1'b0;
            disp_stall = 1'b0;
        end else if (disp_valid) begin
            disp_done  = 1'b1;
            disp_stall = hstall_mode;
            last_dw0   = disp_dw0;
            last_op    = disp_op;
            n_disp++;
        end
    end

    // output monitor
    initial forever begin
        @(negedge clk);
        if (refresh == '1) n_ref++;
        else if (refresh != '0) n_ref_bad++;
        if (cfg_err) n_err++;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        n_fetch = 0; n_disp = 0; n_ref = 0; n_ref_bad = 0; n_err = 0;
        rst_n = 1'b1;
    endtask

    task automatic push(input logic [OW-1:0] v);
        @(negedge clk);
        wr = v;
        wr_upd = 1'b1;
        @(negedge clk);
        wr_upd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        chk("R1 rd", 64'(rd), 64'd0);
        chk("R1 stalled", 64'(stalled), 64'd0);
        chk("R1 idle", 64'({mem_req, disp_valid}), 64'd0);

        // R5 R6 R7 R8 R9 R10 R11: two packets per vector
        for (int i = 0; i < 6; i++) begin
            cur_op = VEC[i].op;
            berr_mode = VEC[i].berr;
            hstall_mode = VEC[i].hstall;
            base = 48'h0000_1234_5000;
            size = 8'd0;
            do_reset();
            push(15'd2);
            repeat (40) @(negedge clk);
            chk($sformatf("R7/R8 rd vec%0d", i), 64'(rd), 64'(VEC[i].exp_rd));
            chk($sformatf("R6/R8 stalled vec%0d", i), 64'(stalled), 64'(VEC[i].exp_st));
            chk($sformatf("R9/R11 dispatches vec%0d", i), 64'(n_disp), 64'(VEC[i].exp_disp));
            chk($sformatf("R10 refresh vec%0d", i), 64'(n_ref), 64'(VEC[i].exp_ref));
            chk($sformatf("R10 partial refresh vec%0d", i), 64'(n_ref_bad), 64'd0);
            chk($sformatf("R5 address vec%0d", i), 64'(last_addr),
                64'(base + (VEC[i].exp_st ? 48'd0 : 48'd32)));
            if (VEC[i].exp_disp != 0) begin
                chk($sformatf("R11 opcode vec%0d", i), 64'(last_op), 64'(VEC[i].op));
                chk($sformatf("R11 dw0 vec%0d", i), last_dw0,
                    {8'h00, base + (VEC[i].exp_st ? 48'd0 : 48'd32), VEC[i].op});
            end
        end

        // R13: stalled queue ignores new updates
        begin
            int f0;
            f0 = n_fetch;
            push(15'd3);
            repeat (20) @(negedge clk);
            chk("R13 rd frozen", 64'(rd), 64'd0);
            chk("R13 still stalled", 64'(stalled), 64'd1);
            chk("R13 no fetch", 64'(n_fetch), 64'(f0));
        end

        // R7 wrap and R5 sequence
        cur_op = 8'h05; berr_mode = 0; hstall_mode = 0;
        base = 48'h8000_0000_0000;
        size = 8'd0;
        do_reset();
        push(15'd100);
        repeat (500) @(negedge clk);
        chk("R5 run to 100", 64'(rd), 64'd100);
        push(15'd20);
        repeat (300) @(negedge clk);
        chk("R7 wrap rd", 64'(rd), 64'd20);
        chk("R5 fetch count", 64'(n_fetch), 64'd148);
        chk("R5 last address", 64'(last_addr), 64'(base + 48'd19 * 48'd32));

        // R3 out of range write offset
        do_reset();
        push(15'd128);
        repeat (20) @(negedge clk);
        chk("R3 error pulses", 64'(n_err), 64'd1);
        chk("R3 no fetch", 64'(n_fetch), 64'd0);
        chk("R3 rd", 64'(rd), 64'd0);

        // R4 larger ring accepts offset 200
        size = 8'd1;
        do_reset();
        push(15'd200);
        repeat (900) @(negedge clk);
        chk("R4 rd", 64'(rd), 64'd200);
        chk("R4 no error", 64'(n_err), 64'd0);
        size = 8'd0;

        // R12 update while busy
        do_reset();
        push(15'd5);
        repeat (3) @(negedge clk);
        push(15'd9);
        repeat (80) @(negedge clk);
        chk("R12 rd", 64'(rd), 64'd9);
        chk("R12 fetches", 64'(n_fetch), 64'd9);

        // R2 enable gating
        do_reset();
        en = 1'b0;
        push(15'd3);
        repeat (30) @(negedge clk);
        chk("R2 disabled rd", 64'(rd), 64'd0);
        chk("R2 disabled fetch", 64'(n_fetch), 64'd0);
        en = 1'b1;
        repeat (40) @(negedge clk);
        chk("R2 resumed rd", 64'(rd), 64'd3);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule